// File: doc/BRIEF.md
# Packed Byte-Instruction Fetch and Decode Buffer

This block is the front end of a stack processor whose instructions are single bytes. It reads one 32-bit word from instruction memory, which carries four instructions, and spends two clock cycles decoding the word into a four-entry decode cache. The first usable entry then moves into a current-instruction register that the execute stage reads. Each advance request from the execute stage brings up the next entry.

Each entry is replaced by a refetch marker once it has been taken out of the cache. Entries that come before the start position of a redirect are also marked. When an advance would reach a marked entry, the controller steps to the next word and fetches again. A build option selects how the refetch starts. In one variant the request goes out in the cycle after the advance. In the other, the controller spends one extra cycle moving to the fetch state first. A redirect can arrive in any state. It discards everything buffered or in flight and restarts at the target. The target's low address bits choose which byte of the fetched word runs first.

Top module: `ibuf_frontend`

## Requirements
- R1: During reset and in the first cycle after it, `mem_req_o` is 1, `mem_addr_o` is 0 and `cur_valid_o` is 0.
- R2: `mem_addr_o` always has its two low bits at 0. Once a request is raised, `mem_req_o` and `mem_addr_o` stay unchanged until `mem_ack_i` is sampled high or a redirect occurs.
- R3: Bytes within a fetched word run most-significant first. The byte in bits [31:24] belongs to address word+0 and the byte in bits [7:0] to word+3. `cur_byte_o` is always the memory byte at address `cur_pc_o`.
- R4: `cur_valid_o` is 0 in the two decode cycles after the cycle whose clock edge accepts `mem_ack_i`. It becomes 1 in the third cycle after that edge.
- R5: Decoding uses `cur_kind_o` = 1 (immediate) when byte bit 7 is 1, with `cur_imm_o` = byte bits [6:0]. It uses 2 (basic) when bits [7:4] are 0, and 3 (extended) otherwise. In both of the last two cases `cur_imm_o` is 0. Kind 0 is the internal refetch marker and is never shown while valid.
- R6: When `cur_valid_o` is 1 and `adv_i` is 1 on an edge, and the current byte is not the last of its word, the next cycle presents address `cur_pc_o`+1 with valid still 1. When `adv_i` is 0, all current outputs hold.
- R7: Advancing past the byte at offset 3 drops `cur_valid_o` in the next cycle and fetches the next word (address +4, wrapping). With FAST_FETCH=1, `mem_req_o` is 1 in that next cycle. With FAST_FETCH=0, that cycle has `mem_req_o` at 0 and the request follows one cycle later.
- R8: `adv_i` has no effect while `cur_valid_o` is 0. No buffered instruction is skipped.
- R9: A redirect causes a fetch request at the aligned target in the next cycle, with `cur_valid_o` at 0. An acknowledge that arrives in the redirect cycle is discarded. The first instruction then presented is at the exact target address.
- R10: `cur_valid_o` and `mem_req_o` are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_addr_o | output | ADDR_W | Word-aligned byte address of the instruction fetch |
| mem_req_o | output | 1 | Fetch request, held until acknowledged |
| mem_ack_i | input | 1 | Memory acknowledge; read data valid in the same cycle |
| mem_rdata_i | input | WORD_W | Fetched instruction word |
| adv_i | input | 1 | Execute stage consumes the current instruction |
| redir_i | input | 1 | Branch or redirect request |
| redir_addr_i | input | ADDR_W | Byte address of the redirect target |
| cur_valid_o | output | 1 | Current instruction is valid |
| cur_kind_o | output | 2 | Decoded class of the current instruction |
| cur_imm_o | output | 7 | Immediate field of the current instruction |
| cur_byte_o | output | 8 | Raw opcode byte of the current instruction |
| cur_pc_o | output | ADDR_W | Byte address of the current instruction |

## Verification
The checker covers the rules that hold on every cycle:
- fetch address alignment and request stability;
- valid and request never being high together;
- the decode classes;
- holding without an advance, the +1 step on an advance, and the refetch target at the end of a word;
- the variant-specific request timing after that refetch;
- the fetch that a redirect starts.

Other behaviour only the bench scenarios can show:
- that the presented byte is the right memory byte in most-significant-first order;
- the exact three-cycle latency from acknowledge to valid;
- that advances during fetch or decode skip nothing;
- that a redirect colliding with an acknowledge drops the stale word and starts at the correct slot.

The sweep covers every start offset at several bases, including address wrap, under several memory latencies.

// File: rtl/ibuf_pkg.sv
package ibuf_pkg;

    // Decoded class of one instruction byte; KIND_MARK is the refetch marker.
    typedef enum logic [1:0] {
        KIND_MARK  = 2'd0,
        KIND_IMM   = 2'd1,
        KIND_BASIC = 2'd2,
        KIND_EXT   = 2'd3
    } kind_e;

    typedef struct packed {
        kind_e      kind;
        logic [6:0] imm;
        logic [7:0] op;
    } dec_t;

    localparam dec_t MARK_ENTRY = '{kind: KIND_MARK, imm: 7'd0, op: 8'd0};

    // ST_FETCH is encoded as zero so an all-zero reset lands in it.
    typedef enum logic [2:0] {
        ST_FETCH   = 3'd0,
        ST_DEC1    = 3'd1,
        ST_DEC2    = 3'd2,
        ST_RUN     = 3'd3,
        ST_GOFETCH = 3'd4
    } state_e;

endpackage

// File: rtl/ibuf_byte_decode.sv
module ibuf_byte_decode
    import ibuf_pkg::*;
(
    input  logic [7:0] op_i,
    output dec_t       dec_o
);

    always_comb begin
        dec_o.op  = op_i;
        dec_o.imm = 7'd0;
        if (op_i[7]) begin
            dec_o.kind = KIND_IMM;
            dec_o.imm  = op_i[6:0];
        end else if (op_i[6:4] == 3'b000) begin
            dec_o.kind = KIND_BASIC;
        end else begin
            dec_o.kind = KIND_EXT;
        end
    end

endmodule

// File: rtl/ibuf_slot_step.sv
module ibuf_slot_step #(
    parameter  int SLOTS = 4,
    localparam int IDX_W = $clog2(SLOTS)
) (
    input  logic [IDX_W-1:0] idx_i,
    input  logic [SLOTS-1:0] mark_i,
    output logic [IDX_W-1:0] next_o,
    output logic             hit_mark_o
);

    always_comb begin
        if (idx_i == IDX_W'(SLOTS - 1)) begin
            next_o = '0;
        end else begin
            next_o = idx_i + IDX_W'(1);
        end
        hit_mark_o = mark_i[next_o];
    end

endmodule

// File: rtl/ibuf_frontend.sv
module ibuf_frontend
    import ibuf_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int WORD_W     = 32,
    parameter bit FAST_FETCH = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic              mem_req_o,
    input  logic              mem_ack_i,
    input  logic [WORD_W-1:0] mem_rdata_i,
    input  logic              adv_i,
    input  logic              redir_i,
    input  logic [ADDR_W-1:0] redir_addr_i,
    output logic              cur_valid_o,
    output logic [1:0]        cur_kind_o,
    output logic [6:0]        cur_imm_o,
    output logic [7:0]        cur_byte_o,
    output logic [ADDR_W-1:0] cur_pc_o
);

    localparam int                SLOTS     = WORD_W / 8;
    localparam int                IDX_W     = $clog2(SLOTS);
    localparam logic [ADDR_W-1:0] WORD_STEP = ADDR_W'(SLOTS);

    typedef struct packed {
        state_e             state;
        logic [ADDR_W-1:0]  word_addr;
        logic [IDX_W-1:0]   start;
        logic [WORD_W-1:0]  raw;
        dec_t [SLOTS-1:0]   slot;
        dec_t               cur;
        logic [IDX_W-1:0]   cur_idx;
    } regs_t;

    regs_t q, d;

    dec_t [SLOTS-1:0] dec_w;
    logic [SLOTS-1:0] mark_w;
    logic [IDX_W-1:0] next_idx;
    logic             next_is_mark;

    // One decoder per byte lane; lane 0 is the most significant byte.
    generate
        for (genvar g = 0; g < SLOTS; g++) begin : g_lane
            ibuf_byte_decode u_dec (
                .op_i  (q.raw[WORD_W-1-8*g -: 8]),
                .dec_o (dec_w[g])
            );
            assign mark_w[g] = (q.slot[g].kind == KIND_MARK);
        end
    endgenerate

    ibuf_slot_step #(.SLOTS(SLOTS)) u_step (
        .idx_i      (q.cur_idx),
        .mark_i     (mark_w),
        .next_o     (next_idx),
        .hit_mark_o (next_is_mark)
    );

    always_comb begin
        d = q;
        unique case (q.state)
            ST_FETCH: begin
                if (mem_ack_i) begin
                    d.raw   = mem_rdata_i;
                    d.state = ST_DEC1;
                end
            end
            ST_DEC1: begin
                // Lanes ahead of the start offset are never executed.
                for (int i = 0; i < SLOTS; i++) begin
                    d.slot[i] = (IDX_W'(i) < q.start) ? MARK_ENTRY : dec_w[i];
                end
                d.state = ST_DEC2;
            end
            ST_DEC2: begin
                d.cur           = q.slot[q.start];
                d.slot[q.start] = MARK_ENTRY;
                d.cur_idx       = q.start;
                d.state         = ST_RUN;
            end
            ST_RUN: begin
                if (adv_i) begin
                    if (next_is_mark) begin
                        d.word_addr = q.word_addr + WORD_STEP;
                        d.start     = '0;
                        d.state     = FAST_FETCH ? ST_FETCH : ST_GOFETCH;
                    end else begin
                        d.cur            = q.slot[next_idx];
                        d.slot[next_idx] = MARK_ENTRY;
                        d.cur_idx        = next_idx;
                    end
                end
            end
            ST_GOFETCH: begin
                d.state = ST_FETCH;
            end
            default: begin
                d.state = ST_FETCH;
            end
        endcase

        // A redirect overrides everything, including a same-cycle acknowledge.
        if (redir_i) begin
            d.state     = ST_FETCH;
            d.word_addr = {redir_addr_i[ADDR_W-1:IDX_W], IDX_W'(0)};
            d.start     = redir_addr_i[IDX_W-1:0];
            for (int i = 0; i < SLOTS; i++) begin
                d.slot[i] = MARK_ENTRY;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign mem_addr_o  = q.word_addr;
    assign mem_req_o   = (q.state == ST_FETCH);
    assign cur_valid_o = (q.state == ST_RUN);
    assign cur_kind_o  = q.cur.kind;
    assign cur_imm_o   = q.cur.imm;
    assign cur_byte_o  = q.cur.op;
    assign cur_pc_o    = {q.word_addr[ADDR_W-1:IDX_W], q.cur_idx};

endmodule

// File: rtl/ibuf_frontend_chk.sv
module ibuf_frontend_chk #(
    parameter int ADDR_W     = 16,
    parameter int WORD_W     = 32,
    parameter bit FAST_FETCH = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] mem_addr_o,
    input logic              mem_req_o,
    input logic              mem_ack_i,
    input logic              adv_i,
    input logic              redir_i,
    input logic [ADDR_W-1:0] redir_addr_i,
    input logic              cur_valid_o,
    input logic [1:0]        cur_kind_o,
    input logic [6:0]        cur_imm_o,
    input logic [7:0]        cur_byte_o,
    input logic [ADDR_W-1:0] cur_pc_o
);

    localparam int SLOTS = WORD_W / 8;
    localparam int IDX_W = $clog2(SLOTS);

    logic last_slot;
    assign last_slot = &cur_pc_o[IDX_W-1:0];

    // R2
    addr_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_addr_o[IDX_W-1:0] == '0);

    // R2
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o && !mem_ack_i && !redir_i |=> mem_req_o && $stable(mem_addr_o));

    // R4
    ack_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o && mem_ack_i && !redir_i |=> !cur_valid_o);

    // R5
    imm_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cur_valid_o && cur_byte_o[7] |-> cur_kind_o == 2'd1 && cur_imm_o == cur_byte_o[6:0]);

    // R5
    basic_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cur_valid_o && cur_byte_o[7:4] == 4'd0 |-> cur_kind_o == 2'd2 && cur_imm_o == 7'd0);

    // R5
    ext_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cur_valid_o && !cur_byte_o[7] && cur_byte_o[6:4] != 3'd0 |->
            cur_kind_o == 2'd3 && cur_imm_o == 7'd0);

    // R6
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cur_valid_o && !adv_i && !redir_i |=>
            cur_valid_o && $stable(cur_byte_o) && $stable(cur_pc_o) && $stable(cur_kind_o));

    // R6
    step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cur_valid_o && adv_i && !redir_i && !last_slot |=>
            cur_valid_o && cur_pc_o == $past(cur_pc_o) + ADDR_W'(1));

    // R7
    refetch_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cur_valid_o && adv_i && !redir_i && last_slot |=>
            !cur_valid_o && mem_addr_o == $past({cur_pc_o[ADDR_W-1:IDX_W], IDX_W'(0)}) + ADDR_W'(SLOTS));

    generate
        if (FAST_FETCH) begin : g_fast
            // R7
            fast_refetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
                cur_valid_o && adv_i && !redir_i && last_slot |=> mem_req_o);
        end else begin : g_slow
            // R7
            slow_refetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
                cur_valid_o && adv_i && !redir_i && last_slot |=> !mem_req_o);
        end
    endgenerate

    // R9
    redir_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        redir_i |=> !cur_valid_o && mem_req_o &&
            mem_addr_o == {$past(redir_addr_i[ADDR_W-1:IDX_W]), IDX_W'(0)});

    // R10
    valid_req_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cur_valid_o && mem_req_o));

endmodule

bind ibuf_frontend ibuf_frontend_chk #(
    .ADDR_W     (ADDR_W),
    .WORD_W     (WORD_W),
    .FAST_FETCH (FAST_FETCH)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .mem_addr_o   (mem_addr_o),
    .mem_req_o    (mem_req_o),
    .mem_ack_i    (mem_ack_i),
    .adv_i        (adv_i),
    .redir_i      (redir_i),
    .redir_addr_i (redir_addr_i),
    .cur_valid_o  (cur_valid_o),
    .cur_kind_o   (cur_kind_o),
    .cur_imm_o    (cur_imm_o),
    .cur_byte_o   (cur_byte_o),
    .cur_pc_o     (cur_pc_o)
);

// File: tb/ibuf_frontend_tb.sv
`timescale 1ns/1ps
module ibuf_frontend_tb;

    localparam int ADDR_W = 16;
    localparam int WORD_W = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    // Fast-fetch instance
    logic [ADDR_W-1:0] mem_addr, redir_addr, pc;
    logic              mem_req, ack, adv, redir, valid;
    logic [WORD_W-1:0] rdata;
    logic [1:0]        kind;
    logic [6:0]        imm;
    logic [7:0]        opb;

    // Slow-fetch instance
    logic [ADDR_W-1:0] s_addr, s_redir_addr, s_pc;
    logic              s_req, s_ack, s_adv, s_redir, s_valid;
    logic [WORD_W-1:0] s_rdata;
    logic [1:0]        s_kind;
    logic [6:0]        s_imm;
    logic [7:0]        s_opb;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    int lat = 5;
    int ack_cyc = 0;
    bit done = 1'b0;

    ibuf_frontend #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .FAST_FETCH(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n), .mem_addr_o(mem_addr), .mem_req_o(mem_req),
        .mem_ack_i(ack), .mem_rdata_i(rdata), .adv_i(adv), .redir_i(redir),
        .redir_addr_i(redir_addr), .cur_valid_o(valid), .cur_kind_o(kind),
        .cur_imm_o(imm), .cur_byte_o(opb), .cur_pc_o(pc)
    );

    ibuf_frontend #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .FAST_FETCH(1'b0)) u_dut_slow (
        .clk(clk), .rst_n(rst_n), .mem_addr_o(s_addr), .mem_req_o(s_req),
        .mem_ack_i(s_ack), .mem_rdata_i(s_rdata), .adv_i(s_adv), .redir_i(s_redir),
        .redir_addr_i(s_redir_addr), .cur_valid_o(s_valid), .cur_kind_o(s_kind),
        .cur_imm_o(s_imm), .cur_byte_o(s_opb), .cur_pc_o(s_pc)
    );

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [7:0] mem_byte(input logic [ADDR_W-1:0] a);
        logic [15:0] t;
        t = a * 16'd53 + 16'd29 + {4'd0, a[15:4]};
        return t[7:0] ^ t[15:8];
    endfunction

    function automatic logic [WORD_W-1:0] word_at(input logic [ADDR_W-1:0] a);
        return {mem_byte(a), mem_byte(a + 16'd1), mem_byte(a + 16'd2), mem_byte(a + 16'd3)};
    endfunction

    function automatic logic [1:0] exp_kind(input logic [7:0] b);
        if (b[7]) return 2'd1;
        if (b[7:4] == 4'd0) return 2'd2;
        return 2'd3;
    endfunction

    function automatic logic [6:0] exp_imm(input logic [7:0] b);
        return b[7] ? b[6:0] : 7'd0;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Memory responder for the fast instance
    initial begin
        int wait_n;
        wait_n = 0;
        ack = 1'b0;
        rdata = '0;
        forever begin
            @(negedge clk);
            ack = 1'b0;
            if (mem_req && rst_n) begin
                if (wait_n >= lat) begin
                    ack = 1'b1;
                    rdata = word_at(mem_addr);
                    ack_cyc = cyc;
                    wait_n = 0;
                end else begin
                    wait_n++;
                end
            end else begin
                wait_n = 0;
            end
        end
    end

    // Memory responder for the slow instance (zero latency)
    initial begin
        s_ack = 1'b0;
        s_rdata = '0;
        forever begin
            @(negedge clk);
            s_ack = 1'b0;
            if (s_req && rst_n) begin
                s_ack = 1'b1;
                s_rdata = word_at(s_addr);
            end
        end
    end

    task automatic run_seq(input logic [ADDR_W-1:0] tgt, input int n, input int gap);
        logic [ADDR_W-1:0] exp_pc;
        logic [ADDR_W-1:0] exp_word;
        logic [7:0]        b;
        bit                fresh;
        @(negedge clk);
        redir = 1'b1;
        redir_addr = tgt;
        @(negedge clk);
        redir = 1'b0;
        exp_word = {tgt[ADDR_W-1:2], 2'b00};
        chk(!valid && mem_req, "R9 redirect starts a fetch", {valid, mem_req}, 2'b01);
        chk(mem_addr == exp_word, "R9 aligned fetch address", mem_addr, exp_word);
        // R8: advance held high through fetch and decode must be ignored
        adv = 1'b1;
        while (!valid) @(negedge clk);
        adv = 1'b0;
        exp_pc = tgt;
        fresh = 1'b1;
        for (int k = 0; k < n; k++) begin
            while (!valid) @(negedge clk);
            if (fresh) chk(cyc - ack_cyc == 3, "R4 acknowledge to valid latency", cyc - ack_cyc, 3);
            fresh = 1'b0;
            b = mem_byte(exp_pc);
            if (k == 0) chk(pc == exp_pc, "R8/R9 first instruction at target", pc, exp_pc);
            else        chk(pc == exp_pc, "R3 instruction address", pc, exp_pc);
            chk(opb == b, "R3 byte order within word", opb, b);
            chk(kind == exp_kind(b) && imm == exp_imm(b), "R5 decoded class and immediate",
                {kind, imm}, {exp_kind(b), exp_imm(b)});
            chk(!mem_req, "R10 no request while valid", mem_req, 0);
            if (gap > 0) begin
                repeat (gap) @(negedge clk);
                chk(valid && pc == exp_pc && opb == b, "R6 hold without advance", pc, exp_pc);
            end
            adv = 1'b1;
            @(negedge clk);
            adv = 1'b0;
            if (exp_pc[1:0] == 2'b11) begin
                exp_word = {exp_pc[ADDR_W-1:2], 2'b00} + 16'd4;
                chk(!valid && mem_req, "R7 fast refetch request", {valid, mem_req}, 2'b01);
                chk(mem_addr == exp_word, "R7 next word address", mem_addr, exp_word);
                fresh = 1'b1;
            end else begin
                chk(valid && pc == exp_pc + 16'd1, "R6 advance to next byte", pc, exp_pc + 16'd1);
            end
            exp_pc = exp_pc + 16'd1;
        end
    endtask

    initial begin
        logic [ADDR_W-1:0] bases [4];
        bases[0] = 16'h0000;
        bases[1] = 16'h0124;
        bases[2] = 16'h5A38;
        bases[3] = 16'hFFF4;
        adv = 1'b0; redir = 1'b0; redir_addr = '0;
        s_adv = 1'b0; s_redir = 1'b0; s_redir_addr = '0;

        // R1: reset state
        repeat (4) @(negedge clk);
        chk(mem_req && mem_addr == 16'd0 && !valid, "R1 state during reset",
            {mem_req, valid, mem_addr}, {1'b1, 1'b0, 16'd0});
        rst_n = 1'b1;
        @(negedge clk);
        chk(mem_req && mem_addr == 16'd0 && !valid, "R1 state after reset",
            {mem_req, valid, mem_addr}, {1'b1, 1'b0, 16'd0});
        // R2: request held while memory stalls
        repeat (2) @(negedge clk);
        chk(mem_req && mem_addr == 16'd0, "R2 request held until acknowledge",
            {mem_req, mem_addr}, {1'b1, 16'd0});
        chk(!valid, "R4 no valid before acknowledge", valid, 0);

        // Sweep: every start offset, several bases and memory latencies
        for (int bi = 0; bi < 4; bi++) begin
            for (int off = 0; off < 4; off++) begin
                lat = (bi + off) % 3;
                run_seq(bases[bi] + 16'(off), 9, (off % 2) * 2);
            end
        end

        // R9: redirect colliding with an acknowledge discards the stale word
        lat = 0;
        @(negedge clk);
        redir = 1'b1;
        redir_addr = 16'h0300;
        @(negedge clk);
        redir = 1'b1;
        redir_addr = 16'h0405;
        @(negedge clk);
        redir = 1'b0;
        while (!valid) @(negedge clk);
        chk(pc == 16'h0405, "R9 stale acknowledge discarded", pc, 16'h0405);
        chk(opb == mem_byte(16'h0405), "R9 byte after collided redirect", opb, mem_byte(16'h0405));

        // R7: slow variant spends one extra cycle before requesting
        @(negedge clk);
        s_redir = 1'b1;
        s_redir_addr = 16'h0043;
        @(negedge clk);
        s_redir = 1'b0;
        while (!s_valid) @(negedge clk);
        chk(s_pc == 16'h0043 && s_opb == mem_byte(16'h0043), "R9 slow variant redirect target",
            s_pc, 16'h0043);
        s_adv = 1'b1;
        @(negedge clk);
        s_adv = 1'b0;
        chk(!s_valid && !s_req, "R7 slow variant transition cycle", {s_valid, s_req}, 2'b00);
        @(negedge clk);
        chk(s_req && s_addr == 16'h0044, "R7 slow variant refetch", {s_req, s_addr}, {1'b1, 16'h0044});
        while (!s_valid) @(negedge clk);
        chk(s_pc == 16'h0044 && s_opb == mem_byte(16'h0044), "R3 slow variant next word",
            s_pc, 16'h0044);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL R6 watchdog: actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule